// File: doc/BRIEF.md
# Multi-Comparator Event Timer

A memory-mapped event timer. A free-running 32-bit up-counter is shared by a small set of comparator channels. Each channel raises an interrupt either once, when the counter steps onto its comparator value, or periodically, by moving its comparator forward by a stored period after every match. Each channel can drive its interrupt as a level, held until software clears it, or as a single-cycle pulse.

The host reaches every register through a simple 32-bit word bus with an address, a write strobe and a read strobe. Software selects an output line for each channel from a fixed per-channel mask of permitted lines. A legacy routing mode overrides this choice for the first two channels and pins them to lines 0 and 8.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, the general configuration word (word 2) and the status word (word 3) all read 0, and every interrupt line is low.
- R2: Word 0 is read-only and reports the vendor code in bits 31:16, a legacy-routing-capable flag set in bit 15, a wide-counter flag clear in bit 13, the channel count minus one in bits 12:8 and the revision in bits 7:0. Word 1 is read-only and reports the tick period in femtoseconds. Writes to either word have no effect.
- R3: The counter (word 4, writable) advances by one on every clock while bit 0 of word 2 is set, and holds its value while that bit is clear. A counter write takes priority over the increment in the same cycle.
- R4: A channel matches when the counter steps to its comparator value by incrementing; a counter write never causes a match. A match sets the channel's bit in word 3 only if the channel's interrupt-enable bit (bit 2 of its configuration word) is set.
- R5: Writing 1 to a bit of word 3 clears that status bit, and writing 0 leaves it unchanged. A match in the same cycle takes priority over the clear.
- R6: A one-shot channel (configuration bit 3 clear) keeps its comparator value after a match, so it fires once per value.
- R7: A periodic channel (bit 3 set) adds its stored period to the comparator on each match, modulo 2^32. Bit 3 can be set only on channels whose read-only capability bit 4 reads 1. The default build allows this on channels 0 and 1.
- R8: A configuration write with bit 6 (value-set) and bit 3 both set arms a two-step load. The next comparator write sets the match time, and the one after it sets the period. Bit 6 always reads 0. Outside this sequence, a comparator write sets only the match time.
- R9: A channel with bit 1 set (level) drives its line while its status bit is set. A channel with bit 1 clear (edge) drives a one-cycle pulse in the same cycle that its status bit becomes set.
- R10: A channel's route field (bits 13:9 of its configuration word) is accepted only if the chosen line is set in the channel's read-only allowed-lines word. Otherwise the previous route is kept.
- R11: While bit 1 of word 2 is set, channel 0 drives line 0 and channel 1 drives line 8, and any other channel routed to line 0 or line 8 drives nothing.
- R12: Unimplemented addresses read 0, and the read data is 0 whenever the read strobe is low. Channel n occupies words 8+4n (configuration), 9+4n (allowed lines) and 10+4n (comparator).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from addr |
| irq | output | NLINES | Interrupt output lines |

## Verification
The hardest situation to reach is a periodic reload that wraps past 2^32, armed through the value-set sequence. The stimulus first loads the counter just below the wrap point. It then runs the configuration write and the two comparator writes before the counter catches up, so the first match lands before the wrap and the reloaded comparator lands after it. Legacy routing is exercised while a third channel is also routed to line 8, so the silencing rule of R11 is observed on an active line.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int          NCH        = 3,
  parameter int          NLINES     = 24,
  parameter int          ADDR_W     = 6,
  parameter logic [15:0] VENDOR_ID  = 16'hA5A5,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [31:0] PERIOD_FS  = 32'd50_000_000,
  parameter logic [NCH-1:0] PER_CAP = 3'b011,
  parameter logic [31:0] ALLOW_MASK = 32'h00F0_0131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [NLINES-1:0] irq
);
  localparam int RW      = 5;
  localparam int CH_BASE = 8;
  localparam logic [ADDR_W-1:0] A_CAPS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_GCFG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);

  logic [31:0]    cnt;
  logic           gen_en, legacy;
  logic [NCH-1:0] status, ie, per, lvl, f32, pulse, match, sig;
  logic [RW-1:0]  route [NCH];
  logic [31:0]    cmp [NCH];
  logic [31:0]    period [NCH];
  logic [1:0]     phase [NCH];

  wire wr_gcfg = wr_en && addr == A_GCFG;
  wire wr_stat = wr_en && addr == A_STAT;
  wire wr_cnt  = wr_en && addr == A_CNT;
  wire [31:0] cnt_inc = cnt + 32'd1;

  function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int off);
    return ADDR_W'(CH_BASE + 4 * ch + off);
  endfunction

  function automatic logic route_ok(input logic [RW-1:0] r);
    return (int'(r) < NLINES) && ALLOW_MASK[r];
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      match[i] = gen_en && !wr_cnt && (cnt_inc == cmp[i]);
      sig[i]   = lvl[i] ? status[i] : pulse[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      gen_en <= 1'b0;
      legacy <= 1'b0;
      status <= '0;
      pulse  <= '0;
    end else begin
      if (wr_cnt)       cnt <= wdata;
      else if (gen_en)  cnt <= cnt_inc;
      if (wr_gcfg) begin
        gen_en <= wdata[0];
        legacy <= wdata[1];
      end
      status <= (status & ~(wr_stat ? wdata[NCH-1:0] : '0)) | (match & ie);
      pulse  <= match & ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie  <= '0;
      per <= '0;
      lvl <= '0;
      f32 <= '0;
      for (int i = 0; i < NCH; i++) begin
        route[i]  <= '0;
        cmp[i]    <= '1;
        period[i] <= '0;
        phase[i]  <= 2'd0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && addr == ch_addr(i, 0)) begin
          ie[i]  <= wdata[2];
          lvl[i] <= wdata[1];
          per[i] <= wdata[3] & PER_CAP[i];
          f32[i] <= wdata[8];
          if (route_ok(wdata[13:9])) route[i] <= wdata[13:9];
          phase[i] <= (wdata[6] && wdata[3] && PER_CAP[i]) ? 2'd1 : 2'd0;
        end
        if (wr_en && addr == ch_addr(i, 2)) begin
          if (phase[i] == 2'd2) begin
            period[i] <= wdata;
            phase[i]  <= 2'd0;
          end else begin
            cmp[i] <= wdata;
            if (phase[i] == 2'd1) phase[i] <= 2'd2;
          end
        end else if (match[i] && per[i]) begin
          cmp[i] <= cmp[i] + period[i];
        end
      end
    end
  end

  always_comb begin
    irq = '0;
    for (int i = 0; i < NCH; i++) begin
      if (legacy && i == 0)
        irq[0] = irq[0] | sig[i];
      else if (legacy && i == 1)
        irq[8] = irq[8] | sig[i];
      else if (!(legacy && (route[i] == RW'(0) || route[i] == RW'(8))))
        irq[route[i]] = irq[route[i]] | sig[i];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_CAPS: rd_data = {VENDOR_ID, 1'b1, 1'b0, 1'b0, 5'(NCH - 1), REV_ID};
        A_PER:  rd_data = PERIOD_FS;
        A_GCFG: rd_data = {30'd0, legacy, gen_en};
        A_STAT: rd_data = 32'(status);
        A_CNT:  rd_data = cnt;
        default: ;
      endcase
      for (int i = 0; i < NCH; i++) begin
        if (addr == ch_addr(i, 0))
          rd_data = {18'd0, route[i], f32[i], 3'b000, PER_CAP[i], per[i], ie[i], lvl[i], 1'b0};
        if (addr == ch_addr(i, 1)) rd_data = ALLOW_MASK;
        if (addr == ch_addr(i, 2)) rd_data = cmp[i];
      end
    end
  end

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en && !wr_cnt |=> $stable(cnt)); // R3

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      wire wr_cmp_g = wr_en && addr == ch_addr(g, 2);
      AST_STATUS_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[g]) |-> $past(ie[g])); // R4
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && wdata[g] && !(match[g] && ie[g]) |=> !status[g]); // R5
      AST_RELOAD_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        match[g] && per[g] && !wr_cmp_g |=> cmp[g] == $past(cmp[g] + period[g])); // R7
      AST_ONESHOT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        match[g] && !per[g] && !wr_cmp_g |=> $stable(cmp[g])); // R6
      AST_PULSE_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[g] |-> status[g]); // R9
    end
  endgenerate
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int NL  = 24;
  localparam logic [31:0] ALLOW = 32'h00F0_0131;
  localparam logic [2:0]  PCAP  = 3'b011;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [NL-1:0] irq;
  int n_cmp = 0, n_bad = 0;
  string rtag = "R12";

  evt_timer uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                 .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state
  logic [31:0] m_cnt = 0;
  bit m_en = 0, m_leg = 0;
  bit [2:0] m_st = 0, m_ie = 0, m_per = 0, m_lvl = 0, m_f32 = 0, m_pul = 0;
  int m_route [3] = '{0, 0, 0};
  int m_ph [3] = '{0, 0, 0};
  logic [31:0] m_cmp [3] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  logic [31:0] m_prd [3] = '{0, 0, 0};

  always @(posedge clk) begin
    bit [2:0] hit;
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_leg = 0; m_st = 0; m_ie = 0; m_per = 0;
      m_lvl = 0; m_f32 = 0; m_pul = 0;
      for (int c = 0; c < 3; c++) begin
        m_route[c] = 0; m_ph[c] = 0; m_cmp[c] = 32'hFFFF_FFFF; m_prd[c] = 0;
      end
    end else begin
      hit = 0;
      for (int c = 0; c < 3; c++)
        if (m_en && !(wr_en && addr == 4) && m_cnt + 1 == m_cmp[c]) hit[c] = 1;
      for (int c = 0; c < 3; c++)
        if (hit[c] && m_per[c] && !(wr_en && addr == 6'(10 + 4 * c)))
          m_cmp[c] = m_cmp[c] + m_prd[c];
      if (wr_en && addr == 4) m_cnt = wdata;
      else if (m_en) m_cnt = m_cnt + 1;
      if (wr_en && addr == 3) m_st = m_st & ~wdata[2:0];
      m_st = m_st | (hit & m_ie);
      m_pul = hit & m_ie;
      if (wr_en && addr == 2) begin m_en = wdata[0]; m_leg = wdata[1]; end
      for (int c = 0; c < 3; c++) begin
        if (wr_en && addr == 6'(8 + 4 * c)) begin
          m_ie[c] = wdata[2]; m_lvl[c] = wdata[1]; m_f32[c] = wdata[8];
          m_per[c] = wdata[3] && PCAP[c];
          if (int'(wdata[13:9]) < NL && ALLOW[wdata[13:9]]) m_route[c] = int'(wdata[13:9]);
          m_ph[c] = (wdata[6] && wdata[3] && PCAP[c]) ? 1 : 0;
        end
        if (wr_en && addr == 6'(10 + 4 * c)) begin
          if (m_ph[c] == 2) begin m_prd[c] = wdata; m_ph[c] = 0; end
          else begin m_cmp[c] = wdata; if (m_ph[c] == 1) m_ph[c] = 2; end
        end
      end
    end
  end

  function automatic logic [NL-1:0] m_irq();
    logic [NL-1:0] v = '0;
    for (int c = 0; c < 3; c++) begin
      bit s = m_lvl[c] ? m_st[c] : m_pul[c];
      if (m_leg && c == 0) v[0] |= s;
      else if (m_leg && c == 1) v[8] |= s;
      else if (!(m_leg && (m_route[c] == 0 || m_route[c] == 8))) v[m_route[c]] |= s;
    end
    return v;
  endfunction

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return {16'hA5A5, 1'b1, 1'b0, 1'b0, 5'd2, 8'h01};
      1: return 32'd50_000_000;
      2: return {30'd0, m_leg, m_en};
      3: return {29'd0, m_st};
      4: return m_cnt;
      default: ;
    endcase
    for (int c = 0; c < 3; c++) begin
      if (a == 8 + 4 * c)
        return {18'd0, 5'(m_route[c]), m_f32[c], 3'b000, PCAP[c], m_per[c], m_ie[c], m_lvl[c], 1'b0};
      if (a == 9 + 4 * c) return ALLOW;
      if (a == 10 + 4 * c) return m_cmp[c];
    end
    return 32'd0;
  endfunction

  always @(negedge clk) begin
    n_cmp++;
    if (irq !== m_irq()) begin
      n_bad++;
      $display("FAIL R9/R11 irq actual=%h expected=%h t=%0t", irq, m_irq(), $time);
    end
    n_cmp++;
    if (rd_data !== (rd_en ? m_read(int'(addr)) : 32'd0)) begin
      n_bad++;
      $display("FAIL %s rd_data @%0d actual=%h expected=%h", rtag, addr, rd_data,
               rd_en ? m_read(int'(addr)) : 32'd0);
    end
  end

  task automatic bwr(input int a, input logic [31:0] d);
    @(posedge clk); #1; addr = 6'(a); wdata = d; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic brd(input int a, input string tag);
    @(posedge clk); #1; addr = 6'(a); rd_en = 1; rtag = tag;
    @(posedge clk); #1; rd_en = 0; rtag = "R12";
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3); #1; rst_n = 1;
    // R1 reset values
    brd(2, "R1"); brd(3, "R1"); brd(4, "R1");
    // R2 identification words, writes ignored
    brd(0, "R2"); brd(1, "R2");
    bwr(0, 32'hFFFF_FFFF); bwr(1, 32'h1234_5678);
    brd(0, "R2"); brd(1, "R2");
    // R12 unimplemented addresses and idle read strobe
    brd(5, "R12"); brd(7, "R12"); brd(63, "R12"); brd(20, "R12"); idle(2);
    // R3 frozen then running counter
    bwr(4, 32'd100); idle(3); brd(4, "R3");
    bwr(2, 32'd1); idle(5); brd(4, "R3"); brd(4, "R3");
    // R4 R6 R9 one-shot edge channel 2 on line 4
    bwr(8 + 8, 32'h4 | (4 << 9)); brd(16, "R10");
    bwr(4, 32'h1F0); bwr(18, 32'h200); idle(20);
    brd(3, "R4"); brd(18, "R6");
    bwr(3, 32'h0); brd(3, "R5"); bwr(3, 32'h4); brd(3, "R5");
    // R10 disallowed route 3 kept at 4
    bwr(16, 32'h4 | (3 << 9)); brd(16, "R10");
    // R7 periodic refused on channel 2
    bwr(16, 32'hC | (4 << 9)); brd(16, "R7");
    // R8 value-set load with wrapping reload, level channel 0 on line 5 (R7 R9)
    bwr(4, 32'hFFFF_FFF0);
    bwr(8, 32'h4E | (5 << 9)); brd(8, "R8");
    bwr(10, 32'hFFFF_FFFA); bwr(10, 32'd8);
    brd(10, "R8"); idle(6); brd(10, "R7"); brd(3, "R9");
    idle(4); bwr(3, 32'h1); brd(3, "R5"); idle(10); brd(10, "R7");
    bwr(3, 32'h1); idle(6);
    // R4 channel 1 not enabled: no status
    bwr(4, 32'h500); bwr(14, 32'h508); idle(15); brd(3, "R4");
    // R11 legacy routing, ch1 periodic edge, ch2 routed to line 8 silenced
    bwr(12, 32'h48 | 32'h4 | (20 << 9)); bwr(14, 32'h540); bwr(14, 32'd6);
    bwr(16, 32'h4 | (8 << 9)); bwr(18, 32'h550);
    bwr(2, 32'h3); brd(2, "R11"); idle(40);
    bwr(3, 32'h7); idle(10);
    bwr(2, 32'h1); idle(20); bwr(3, 32'h7);
    // R3 disable freezes
    bwr(2, 32'h0); brd(4, "R3"); idle(5); brd(4, "R3");
    bwr(8, 32'h0); bwr(12, 32'h0); bwr(16, 32'h0);
    idle(3);
    finish_run();
  end
endmodule